// File: doc/BRIEF.md
# Burst-Counted SPI Master

This block is a register-mapped SPI master that runs one chip-select burst per start command. Software loads command and address bytes into a transmit FIFO, sets a total burst length and a shorter leading send count, and sets an exchange bit. The block shifts the first send-count bytes out of the transmit FIFO. It then keeps clocking zero filler bytes until the burst length is reached. Every byte seen on the data input during the burst goes into a receive FIFO, including the bytes clocked while the header was going out.

The typical use is a flash read. A four-byte command header is pushed, the burst length is set to header plus payload, and the send count is set to four. When the exchange bit reads back as zero, software discards the first four received bytes and pops the payload. The serial clock is always SPI mode 0: it idles low, data is sampled on the rising edge and changes on the falling edge. A divider register sets the serial clock rate.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, chip select (`spi_cs_n`) is high, `spi_sclk` is low and `spi_mosi` is low. Every register reads 0 and both FIFOs are empty. Register word addresses are: 0 control, 1 status, 2 burst length, 3 send count, 4 divider, 5 transmit data, 6 receive data.
- R2: Writing the control register with bit 4 (exchange) set starts a burst only if bit 0 (enable) and bit 1 (master) are also set in the same write. Otherwise the write has no effect on the serial pins and bit 4 reads 0. Once a burst starts, bit 4 reads 1 and chip select is low for exactly the burst. Bit 4 clears on the same cycle that chip select rises.
- R3: Byte i of the burst (counting from 0) is popped from the transmit FIFO if i is below the send count, and is sent as 0x00 otherwise. A byte that is due from an empty transmit FIFO is also sent as 0x00. Bits go out most significant first.
- R4: Every byte clocked in on `spi_miso` is pushed into the receive FIFO in arrival order, including header-time bytes. A byte that arrives while the receive FIFO is full is dropped.
- R5: The status register holds the receive FIFO level in bits [6:0] and the transmit FIFO level in bits [14:8]. A full 64-entry FIFO reads as 64.
- R6: Each half period of the serial clock lasts div[7:0]+1 module clock cycles, where div is the divider register. The value 0x1001 gives the module clock divided by 4 and 0x1000 gives divide by 2. In each bit, data is stable while `spi_sclk` is high.
- R7: Control bit 2 empties the transmit FIFO and control bit 3 empties the receive FIFO. Both bits always read back 0.
- R8: Control bit 31 starts a soft reset. The bit reads 1 for SRST_CYCLES cycles and then 0. During the soft reset any burst is aborted with chip select high. Both FIFOs are emptied, the burst, send and divider registers are cleared, and bus writes are ignored. Bits 0 and 1 take the values written alongside bit 31.
- R9: A write to the transmit data address pushes its low byte; a write to a full transmit FIFO is dropped. A read of the receive data address returns the oldest byte and pops it. Reading the receive data address while the FIFO is empty returns 0 and changes nothing.
- R10: A start with a burst length of 0 drives no serial clock, keeps chip select high, and clears the exchange bit within two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench builds the block with its defaults: FIFO depth 64, 16-bit counts and a four-cycle soft reset. With depth 64, a 66-byte burst overfills the receive FIFO and makes the level read back exactly 64 in the 7-bit field. With 16-bit counts, a long burst stays running long enough to be cut off by a soft reset. Divider values 0 and 1 cover the two documented rates, and a behavioural model checks chip select, serial clock and output data on every cycle against them.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
    localparam int CNT_W = 16;

    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_e;

    typedef enum logic [2:0] {
        RA_CTRL  = 3'd0,
        RA_STAT  = 3'd1,
        RA_BURST = 3'd2,
        RA_SEND  = 3'd3,
        RA_CDIV  = 3'd4,
        RA_TXD   = 3'd5,
        RA_RXD   = 3'd6
    } reg_addr_e;

    localparam int B_EN    = 0;
    localparam int B_MST   = 1;
    localparam int B_TXCLR = 2;
    localparam int B_RXCLR = 3;
    localparam int B_XCH   = 4;
    localparam int B_SRST  = 31;

    typedef struct packed {
        logic [CNT_W-1:0] burst;
        logic [CNT_W-1:0] send;
        logic [7:0]       half;
    } xfer_cfg_t;

    function automatic logic [7:0] pick_byte(input logic take, input logic [7:0] head);
        return take ? head : 8'h00;
    endfunction
endpackage

// File: rtl/spi_burst_fifo.sv
module spi_burst_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [LVL_W-1:0] level,
    output logic             empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [LVL_W-1:0] cnt;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty   = (cnt == '0);
    assign do_push = push && (cnt != LVL_W'(DEPTH));
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];
    assign level   = cnt;

    always_ff @(posedge clk) begin
        if (do_push && !flush && !rst) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            cnt <= cnt + LVL_W'(do_push) - LVL_W'(do_pop);
        end
    end
endmodule

// File: rtl/spi_burst_shifter.sv
module spi_burst_shifter
    import spi_burst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  xfer_cfg_t  cfg,
    input  logic [7:0] tx_head,
    input  logic       tx_empty,
    input  logic       miso,
    output logic       tx_pop,
    output logic       rx_push,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi,
    output logic       cs_n,
    output logic       done
);
    phase_e           phase;
    xfer_cfg_t        cfg_q;
    logic [7:0]       cnt;
    logic [2:0]       bitn;
    logic [CNT_W-1:0] idx;
    logic [7:0]       sh_tx, sh_rx;
    logic             sclk_q, cs_q;

    logic             half_end, byte_end, last_byte, load, take;
    logic [CNT_W-1:0] load_idx, load_send;
    logic [7:0]       load_byte;

    assign half_end  = (cnt == cfg_q.half);
    assign byte_end  = (phase == PH_HIGH) && half_end && (bitn == 3'd7);
    assign last_byte = (idx + CNT_W'(1)) == cfg_q.burst;

    always_comb begin
        load      = 1'b0;
        load_idx  = '0;
        load_send = cfg_q.send;
        if (phase == PH_IDLE) begin
            load      = start && (cfg.burst != '0);
            load_send = cfg.send;
        end else if (byte_end && !last_byte) begin
            load     = 1'b1;
            load_idx = idx + CNT_W'(1);
        end
        take      = load && (load_idx < load_send) && !tx_empty;
        load_byte = pick_byte(take, tx_head);
    end

    assign tx_pop  = take;
    assign rx_push = byte_end;
    assign rx_byte = sh_rx;
    assign done    = ((phase == PH_IDLE) && start && (cfg.burst == '0)) || (byte_end && last_byte);
    assign sclk    = sclk_q;
    assign cs_n    = cs_q;
    assign mosi    = sh_tx[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cfg_q  <= '0;
            cnt    <= '0;
            bitn   <= '0;
            idx    <= '0;
            sh_tx  <= '0;
            sh_rx  <= '0;
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    cfg_q <= cfg;
                    if (cfg.burst != '0) begin
                        phase <= PH_LOW;
                        cs_q  <= 1'b0;
                        sh_tx <= load_byte;
                        cnt   <= '0;
                        bitn  <= '0;
                        idx   <= '0;
                    end
                end
                PH_LOW: begin
                    if (half_end) begin
                        sclk_q <= 1'b1;
                        sh_rx  <= {sh_rx[6:0], miso};
                        cnt    <= '0;
                        phase  <= PH_HIGH;
                    end else begin
                        cnt <= cnt + 8'd1;
                    end
                end
                PH_HIGH: begin
                    if (half_end) begin
                        sclk_q <= 1'b0;
                        cnt    <= '0;
                        if (bitn == 3'd7) begin
                            if (last_byte) begin
                                phase <= PH_IDLE;
                                cs_q  <= 1'b1;
                                sh_tx <= '0;
                            end else begin
                                idx   <= idx + CNT_W'(1);
                                bitn  <= '0;
                                sh_tx <= load_byte;
                                phase <= PH_LOW;
                            end
                        end else begin
                            bitn  <= bitn + 3'd1;
                            sh_tx <= {sh_tx[6:0], 1'b0};
                            phase <= PH_LOW;
                        end
                    end else begin
                        cnt <= cnt + 8'd1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
    import spi_burst_pkg::*;
#(
    parameter int DEPTH       = 64,
    parameter int SRST_CYCLES = 4,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int SR_W  = $clog2(SRST_CYCLES + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        spi_sclk,
    output logic        spi_mosi,
    output logic        spi_cs_n,
    input  logic        spi_miso
);
    logic             en_q, mst_q, xch_q, start_q;
    logic [CNT_W-1:0] burst_q, send_q;
    logic [15:0]      div_q;
    logic [SR_W-1:0]  srst_cnt;
    logic             srst_busy, core_rst;

    logic             wr_ok, wr_ctrl, tx_flush, rx_flush, tx_push, rx_pop;
    logic [7:0]       tx_head, rx_head, rx_byte;
    logic [LVL_W-1:0] tx_lvl, rx_lvl;
    logic             tx_empty, rx_empty, tx_pop, rx_push, xfer_done;
    xfer_cfg_t        cfg;

    wire unused_bits = ^{reg_wdata[30:16], reg_wdata[7:5], div_q[15:8]};

    assign srst_busy = (srst_cnt != '0);
    assign core_rst  = rst || srst_busy;
    assign wr_ok     = reg_wr && !srst_busy;
    assign wr_ctrl   = wr_ok && (reg_addr == RA_CTRL);
    assign tx_flush  = srst_busy || (wr_ctrl && reg_wdata[B_TXCLR]);
    assign rx_flush  = srst_busy || (wr_ctrl && reg_wdata[B_RXCLR]);
    assign tx_push   = wr_ok && (reg_addr == RA_TXD);
    assign rx_pop    = reg_rd && !srst_busy && (reg_addr == RA_RXD);
    assign cfg       = '{burst: burst_q, send: send_q, half: div_q[7:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            mst_q    <= 1'b0;
            xch_q    <= 1'b0;
            start_q  <= 1'b0;
            burst_q  <= '0;
            send_q   <= '0;
            div_q    <= '0;
            srst_cnt <= '0;
        end else if (srst_busy) begin
            xch_q    <= 1'b0;
            start_q  <= 1'b0;
            burst_q  <= '0;
            send_q   <= '0;
            div_q    <= '0;
            srst_cnt <= srst_cnt - SR_W'(1);
        end else begin
            start_q <= 1'b0;
            if (xfer_done) xch_q <= 1'b0;
            if (wr_ok) begin
                case (reg_addr)
                    RA_CTRL: begin
                        en_q  <= reg_wdata[B_EN];
                        mst_q <= reg_wdata[B_MST];
                        if (reg_wdata[B_SRST]) begin
                            srst_cnt <= SR_W'(SRST_CYCLES);
                        end else if (reg_wdata[B_XCH] && reg_wdata[B_EN] && reg_wdata[B_MST] && !xch_q) begin
                            xch_q   <= 1'b1;
                            start_q <= 1'b1;
                        end
                    end
                    RA_BURST: burst_q <= reg_wdata[CNT_W-1:0];
                    RA_SEND:  send_q  <= reg_wdata[CNT_W-1:0];
                    RA_CDIV:  div_q   <= reg_wdata[15:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[B_EN]   = en_q;
                reg_rdata[B_MST]  = mst_q;
                reg_rdata[B_XCH]  = xch_q;
                reg_rdata[B_SRST] = srst_busy;
            end
            RA_STAT: begin
                reg_rdata[6:0]  = 7'(rx_lvl);
                reg_rdata[14:8] = 7'(tx_lvl);
            end
            RA_BURST: reg_rdata[CNT_W-1:0] = burst_q;
            RA_SEND:  reg_rdata[CNT_W-1:0] = send_q;
            RA_CDIV:  reg_rdata[15:0]      = div_q;
            RA_RXD:   reg_rdata[7:0]       = rx_empty ? 8'h00 : rx_head;
            default: ;
        endcase
    end

    spi_burst_fifo #(.W(8), .DEPTH(DEPTH)) tx_fifo_i (
        .clk(clk), .rst(rst), .flush(tx_flush), .push(tx_push), .din(reg_wdata[7:0]),
        .pop(tx_pop), .dout(tx_head), .level(tx_lvl), .empty(tx_empty)
    );

    spi_burst_fifo #(.W(8), .DEPTH(DEPTH)) rx_fifo_i (
        .clk(clk), .rst(rst), .flush(rx_flush), .push(rx_push), .din(rx_byte),
        .pop(rx_pop), .dout(rx_head), .level(rx_lvl), .empty(rx_empty)
    );

    spi_burst_shifter shifter_i (
        .clk(clk), .rst(core_rst), .start(start_q), .cfg(cfg),
        .tx_head(tx_head), .tx_empty(tx_empty), .miso(spi_miso),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte),
        .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n), .done(xfer_done)
    );
endmodule

// File: rtl/spi_burst_master_chk.sv
module spi_burst_master_chk #(
    parameter int DEPTH = 64,
    parameter int LVL_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             sclk,
    input logic             mosi,
    input logic             xch,
    input logic             srst_busy,
    input logic [LVL_W-1:0] rx_lvl,
    input logic [LVL_W-1:0] tx_lvl
);
    // R2: chip select low only while the exchange bit is set
    a_r2_cs_within_xch: assert property (@(posedge clk) disable iff (rst) !cs_n |-> xch);

    // R2: exchange bit falls together with chip select release
    a_r2_xch_fall_cs_high: assert property (@(posedge clk) disable iff (rst) $fell(xch) |-> cs_n);

    // R6: clock idles low outside a burst
    a_r6_sclk_idle_low: assert property (@(posedge clk) disable iff (rst) cs_n |-> !sclk);

    // R6: data stable while the clock stays high
    a_r6_mosi_hold_high: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk) && !cs_n) |-> $stable(mosi));

    // R5: FIFO levels never pass the depth
    a_r5_rx_level_bound: assert property (@(posedge clk) disable iff (rst) rx_lvl <= LVL_W'(DEPTH));
    a_r5_tx_level_bound: assert property (@(posedge clk) disable iff (rst) tx_lvl <= LVL_W'(DEPTH));

    // R8: soft reset holds the serial side idle
    a_r8_srst_cs_high: assert property (@(posedge clk) disable iff (rst) srst_busy |=> cs_n);
endmodule

bind spi_burst_master spi_burst_master_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
    .clk(clk), .rst(rst), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
    .xch(xch_q), .srst_busy(srst_busy), .rx_lvl(rx_lvl), .tx_lvl(tx_lvl)
);

// File: tb/spi_burst_master_tb_top.sv
`timescale 1ns/1ps
module spi_burst_master_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sclk, spi_mosi, spi_cs_n;
    logic        miso_v = 1'b0;

    int errors = 0, checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    spi_burst_master dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .spi_miso(miso_v)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // serial slave: presents bits MSB first, advances on each rising clock
    logic [7:0] slv_q[$];
    int slv_bit = 0;
    function automatic logic slv_val(input int b);
        if (b / 8 < slv_q.size()) return slv_q[b / 8][7 - (b % 8)];
        return 1'b0;
    endfunction
    always @(posedge spi_sclk or posedge spi_cs_n) begin
        if (spi_cs_n) slv_bit = 0;
        else slv_bit = slv_bit + 1;
        miso_v = slv_val(slv_bit);
    end
    task automatic load_slave(input int n, input int seed);
        slv_q.delete();
        for (int i = 0; i < n; i++) slv_q.push_back(8'((i * 37 + seed) ^ 8'h5A));
        slv_bit = 0;
        miso_v = slv_val(0);
    endtask

    // reference model of the serial pins
    logic [7:0] tx_model[$];
    logic [7:0] m_tx[$];
    bit m_active = 0, m_pause = 0;
    int m_j = 0, m_len = 0, m_h = 1, m_send = 0;

    always @(posedge clk) begin
        #1;
        if (!rst && !m_pause) begin
            if (m_active) begin
                m_j++;
                if (m_j <= m_len) begin
                    int b, byt;
                    logic esc, emo;
                    logic [7:0] ev;
                    b   = (m_j - 1) / (2 * m_h);
                    byt = b / 8;
                    esc = ((m_j - 1) % (2 * m_h)) >= m_h;
                    ev  = (byt < m_send && byt < m_tx.size()) ? m_tx[byt] : 8'h00;
                    emo = ev[7 - (b % 8)];
                    check(spi_cs_n == 1'b0 && spi_sclk == esc && spi_mosi == emo,
                          "R2/R3/R6 pins in burst", {spi_cs_n, spi_sclk, spi_mosi}, {1'b0, esc, emo});
                end else begin
                    check(spi_cs_n && !spi_sclk, "R2 burst end", {spi_cs_n, spi_sclk}, 2'b10);
                    m_active = 0;
                end
            end else begin
                check(spi_cs_n && !spi_sclk, "R2 idle pins", {spi_cs_n, spi_sclk}, 2'b10);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] b);
        wr(3'd5, {24'h0, b});
        if (tx_model.size() < 64) tx_model.push_back(b);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // start a modelled burst with enable, master and exchange
    task automatic run(input int burst, input int send, input int half);
        int used;
        wr(3'd2, burst);
        wr(3'd3, send);
        wr(3'd4, 32'h1000 | half);
        wr(3'd0, 32'h13);
        m_tx.delete();
        foreach (tx_model[i]) m_tx.push_back(tx_model[i]);
        used = send < burst ? send : burst;
        if (used > tx_model.size()) used = tx_model.size();
        repeat (used) void'(tx_model.pop_front());
        m_send = send; m_h = half + 1; m_len = 16 * burst * (half + 1); m_j = 0;
        m_active = (burst != 0);
        wait (!m_active);
        idle(2);
    endtask

    task automatic drain_rx(input int n, input string req);
        logic [31:0] d;
        for (int i = 0; i < n; i++) begin
            rd(3'd6, d);
            check(d[7:0] == slv_q[i], req, d[7:0], slv_q[i]);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(spi_cs_n && !spi_sclk && !spi_mosi, "R1 pins", {spi_cs_n, spi_sclk, spi_mosi}, 3'b100);
        rd(3'd1, d); check(d == 0, "R1 status", d, 0);
        rd(3'd0, d); check(d == 0, "R1 control", d, 0);
        rd(3'd2, d); check(d == 0, "R1 burst", d, 0);

        // R2 exchange ignored without enable/master
        wr(3'd2, 4);
        wr(3'd0, 32'h10);
        idle(20);
        rd(3'd0, d); check(d == 0, "R2 exchange ignored", d, 0);
        wr(3'd0, 32'h12);
        idle(10);
        rd(3'd0, d); check(d == 32'h2, "R2 exchange ignored no enable", d, 2);

        // R3/R4/R6 read-style burst, divide by 4
        push_tx(8'h03); push_tx(8'h12); push_tx(8'h34); push_tx(8'h56);
        rd(3'd1, d); check(d == 32'h0400, "R5 tx level 4", d, 32'h0400);
        load_slave(10, 1);
        run(10, 4, 1);
        rd(3'd0, d); check(d == 32'h3, "R2 exchange self-cleared", d, 3);
        rd(3'd1, d); check(d == 32'h000A, "R5 rx level 10 tx 0", d, 32'h000A);
        drain_rx(10, "R4 rx byte order");

        // R6 divide by 2, all bytes from FIFO
        push_tx(8'hA1); push_tx(8'h7E); push_tx(8'hC3);
        load_slave(3, 9);
        run(3, 3, 0);
        rd(3'd1, d); check(d == 32'h0003, "R6 rx level after div2", d, 3);
        drain_rx(3, "R4 div2 bytes");

        // R3 underrun: send count exceeds FIFO contents
        push_tx(8'hF0); push_tx(8'h0F);
        load_slave(6, 3);
        run(6, 5, 1);
        rd(3'd1, d); check(d == 32'h0006, "R3 underrun levels", d, 6);
        drain_rx(6, "R3 underrun rx");

        // R10 zero-length burst
        wr(3'd2, 0);
        wr(3'd0, 32'h13);
        idle(3);
        rd(3'd0, d); check(d == 32'h3, "R10 zero burst clears exchange", d, 3);

        // R4/R5 receive overflow with 66-byte burst
        load_slave(66, 7);
        run(66, 0, 0);
        rd(3'd1, d); check(d == 32'h0040, "R5 rx level full 64", d, 32'h40);
        drain_rx(64, "R4 rx keeps first 64");
        rd(3'd6, d); check(d == 0, "R9 empty rx read", d, 0);
        rd(3'd1, d); check(d == 0, "R9 empty read no change", d, 0);

        // R9/R5 transmit overflow, R7 FIFO clears
        for (int i = 0; i < 65; i++) push_tx(8'(i));
        rd(3'd1, d); check(d == 32'h4000, "R9 tx push drops when full", d, 32'h4000);
        wr(3'd0, 32'h07);
        tx_model.delete();
        rd(3'd1, d); check(d == 0, "R7 tx clear", d, 0);
        rd(3'd0, d); check(d == 32'h3, "R7 clear bit reads 0", d, 3);
        load_slave(2, 4);
        run(2, 0, 0);
        rd(3'd1, d); check(d == 32'h0002, "R7 rx before clear", d, 2);
        wr(3'd0, 32'h0B);
        rd(3'd1, d); check(d == 0, "R7 rx clear", d, 0);

        // R8 soft reset aborts a long burst
        load_slave(50, 2);
        wr(3'd2, 50); wr(3'd3, 0); wr(3'd4, 32'h1001);
        m_pause = 1;
        wr(3'd0, 32'h13);
        idle(40);
        check(!spi_cs_n, "R8 burst running", spi_cs_n, 0);
        wr(3'd0, 32'h8000_0003);
        rd(3'd0, d); check(d == 32'h8000_0003, "R8 soft reset busy", d, 32'h80000003);
        idle(8);
        rd(3'd0, d); check(d == 32'h3, "R8 soft reset done", d, 3);
        rd(3'd2, d); check(d == 0, "R8 burst cleared", d, 0);
        rd(3'd4, d); check(d == 0, "R8 divider cleared", d, 0);
        rd(3'd1, d); check(d == 0, "R8 fifos emptied", d, 0);
        check(spi_cs_n && !spi_sclk, "R8 pins idle", {spi_cs_n, spi_sclk}, 2'b10);
        m_pause = 0;
        idle(5);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule